// File: doc/BRIEF.md
# Byte-Parallel Configuration Loader

This block sits on the host side of a programmable target device and streams a configuration image into it over an 8-bit bus. A start request makes it drive an active-low configuration request for a fixed number of system clocks. It then waits until the target releases its active-low status line. After that it reads image bytes from a memory port, one byte per configuration clock period. The configuration clock comes from the system clock through a fixed divider. Bytes change only while that clock is low, so each one is stable before the rising edge at which the target captures it.

The target raises its done flag one byte before the end of the image. The loader stops fetching as soon as it sees done at a falling edge, and the missing last byte is not treated as an error. It then drives two falling edges in total after done, parks the clock low, and waits for a rising edge on init-done. The run ends in one of three sticky results: success, error or timeout. Each result stays set until the next start. An error is reported when the status line drops during the transfer, or when the byte count runs out before done rises.

Top module: `cfg_loader`

## Requirements
- R1: While reset is asserted, and after it, until a start: `cfg_req_no`=1, `cfg_clk_o`=0, `mem_rd_o`=0, and `busy_o`, `ok_o`, `err_o` and `tmo_o` are all 0.
- R2: A start from an idle or finished state drives `cfg_req_no` low for exactly REQ_CYC system clocks, once. `busy_o` is 1 for the whole run.
- R3: While `status_ni` is still low after the request, and before the first byte is captured, no memory read is issued and `cfg_clk_o` stays low.
- R4: The image is read from address 0 upward, one single-cycle read per byte with the data one cycle later. Bytes appear on `cfg_data_o` in address order, one per configuration clock period, and `cfg_data_o` never changes while `cfg_clk_o` is high or at its rising edge.
- R5: Every high phase of `cfg_clk_o` lasts HALF_DIV system clocks (HALF_DIV must be at least 3).
- R6: When `done_i` is high at a falling edge of `cfg_clk_o`, no further byte is fetched. The number of bytes read equals the number captured before done, and done on the last byte of the count still counts as success.
- R7: Counting the falling edge at which done is seen, exactly two falling edges of `cfg_clk_o` (with one rising edge between them) occur after `done_i` rises. After that `cfg_clk_o` stays low.
- R8: Success (`ok_o`=1) requires a low-to-high transition of `init_done_i` after the trailing edges. A level that is already high gives no success.
- R9: `status_ni` going low during the transfer or the trailing edges sets `err_o` and stops `cfg_clk_o` within two system clocks.
- R10: If `done_i` is still low at the falling edge that follows the last counted byte (`byte_count_i`), `err_o` is set after exactly that many bytes.
- R11: If no init-done edge arrives within INIT_TMO system clocks after the trailing edges, `tmo_o` is set and `ok_o` stays 0.
- R12: At most one of `ok_o`, `err_o` and `tmo_o` is set. The result is held until the next start, which clears it. A start while `busy_o`=1 is ignored and gives no second request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a configuration run |
| byte_count_i | input | ADDR_W+1 | Image length in bytes, sampled at start |
| mem_addr_o | output | ADDR_W | Image memory address |
| mem_rd_o | output | 1 | Image memory read strobe |
| mem_data_i | input | 8 | Read data, valid one cycle after the strobe |
| cfg_req_no | output | 1 | Configuration request to the target, active low |
| status_ni | input | 1 | Target status, active low |
| done_i | input | 1 | Target has received enough data |
| init_done_i | input | 1 | Target initialization complete |
| cfg_clk_o | output | 1 | Configuration clock to the target |
| cfg_data_o | output | 8 | Configuration byte to the target |
| busy_o | output | 1 | A run is in progress |
| ok_o | output | 1 | Sticky success |
| err_o | output | 1 | Sticky error |
| tmo_o | output | 1 | Sticky init-done timeout |

## Verification
The bench models the target. It releases status late, raises done either one byte early or on the last byte, and supplies an init-done edge, no edge at all, or a level that is high from the start. A loader that misread the early done would fetch one byte too many or flag an error on a good run. One that counted the wrong number of trailing edges would leave an extra rising edge or park the clock high. One that tested the init-done level rather than its edge would report success when the line was already high. The bench also drops status partway through a stream, withholds done until the count runs out, and issues a second start mid-run. A loader that kept clocking after the drop, stopped at the wrong byte or restarted on the second start would show a wrong captured-byte count or a second request pulse.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_REQ, ST_WREL, ST_PRIME, ST_XFER,
    ST_TRAIL, ST_WINIT, ST_PASS, ST_FAIL, ST_TMO
  } ld_state_e;
endpackage

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          clk_q;
  logic          tick;

  assign tick   = en_i && (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o = tick && !clk_q;
  assign fall_o = tick && clk_q;
  assign clk_o  = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/cfg_fetch.sv
module cfg_fetch #(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              req_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [7:0]        mem_data_i,
  output logic [7:0]        data_o,
  output logic              loaded_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;
  logic              lat_q;
  logic [7:0]        data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
      lat_q  <= 1'b0;
      data_q <= '0;
    end else begin
      rd_q  <= req_i;
      lat_q <= rd_q;
      if (clr_i)     addr_q <= '0;
      else if (rd_q) addr_q <= addr_q + ADDR_W'(1);
      if (lat_q) data_q <= mem_data_i;
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_rd_o   = rd_q;
  assign data_o     = data_q;
  assign loaded_o   = lat_q;
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 q <= '0;
    else if (load_i)             q <= load_val_i;
    else if (dec_i && q != '0)   q <= q - W'(1);
  end

  assign zero_o = (q == '0);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int REQ_CYC  = 4,
  parameter int HALF_DIV = 4,
  parameter int INIT_TMO = 300,
  localparam int CNT_W   = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_count_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [7:0]        mem_data_i,
  output logic              cfg_req_no,
  input  logic              status_ni,
  input  logic              done_i,
  input  logic              init_done_i,
  output logic              cfg_clk_o,
  output logic [7:0]        cfg_data_o,
  output logic              busy_o,
  output logic              ok_o,
  output logic              err_o,
  output logic              tmo_o
);
  localparam int TMR_MAX = (REQ_CYC > INIT_TMO) ? REQ_CYC : INIT_TMO;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  ld_state_e         state_q, state_d;
  logic              req_n_q;
  logic [CNT_W-1:0]  sent_q, total_q;
  logic              init_q;

  logic              clk_en, rise, fall;
  logic              fetch_req, loaded, run_start;
  logic              tmr_load, tmr_dec, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;

  cfg_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (clk_en),
    .clk_o (cfg_clk_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  cfg_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (run_start),
    .req_i     (fetch_req),
    .mem_addr_o(mem_addr_o),
    .mem_rd_o  (mem_rd_o),
    .mem_data_i(mem_data_i),
    .data_o    (cfg_data_o),
    .loaded_o  (loaded)
  );

  // one counter serves the request pulse and the init-done watchdog
  cfg_timer #(.W(TMR_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .dec_i     (tmr_dec),
    .zero_o    (tmr_zero)
  );

  assign clk_en = (state_q == ST_XFER) || (state_q == ST_TRAIL);

  always_comb begin
    state_d   = state_q;
    fetch_req = 1'b0;
    run_start = 1'b0;
    tmr_load  = 1'b0;
    tmr_dec   = 1'b0;
    tmr_val   = '0;
    unique case (state_q)
      ST_IDLE, ST_PASS, ST_FAIL, ST_TMO: begin
        if (start_i) begin
          state_d   = ST_REQ;
          run_start = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = TMR_W'(REQ_CYC - 1);
        end
      end
      ST_REQ: begin
        if (tmr_zero) state_d = ST_WREL;
        else          tmr_dec = 1'b1;
      end
      ST_WREL: begin
        if (status_ni) begin
          fetch_req = 1'b1;
          state_d   = ST_PRIME;
        end
      end
      ST_PRIME: begin
        if (!status_ni)  state_d = ST_FAIL;
        else if (loaded) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (!status_ni) state_d = ST_FAIL;
        else if (fall) begin
          if (done_i)                  state_d = ST_TRAIL;
          else if (sent_q == total_q)  state_d = ST_FAIL;
          else                         fetch_req = 1'b1;
        end
      end
      ST_TRAIL: begin
        // the fall that revealed done was the first trailing edge
        if (!status_ni) state_d = ST_FAIL;
        else if (fall) begin
          state_d  = ST_WINIT;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(INIT_TMO);
        end
      end
      ST_WINIT: begin
        if (init_done_i && !init_q) state_d = ST_PASS;
        else if (tmr_zero)          state_d = ST_TMO;
        else                        tmr_dec = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_n_q <= 1'b1;
      sent_q  <= '0;
      total_q <= '0;
      init_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_n_q <= (state_d != ST_REQ);
      init_q  <= init_done_i;
      if (run_start) begin
        sent_q  <= '0;
        total_q <= byte_count_i;
      end else if (rise && state_q == ST_XFER) begin
        sent_q <= sent_q + CNT_W'(1);
      end
    end
  end

  assign cfg_req_no = req_n_q;
  assign ok_o       = (state_q == ST_PASS);
  assign err_o      = (state_q == ST_FAIL);
  assign tmo_o      = (state_q == ST_TMO);
  assign busy_o     = !(state_q inside {ST_IDLE, ST_PASS, ST_FAIL, ST_TMO});
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int HALF_DIV = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_req_no,
  input logic       busy_o,
  input logic       status_ni,
  input logic       done_i,
  input logic       init_done_i,
  input logic       cfg_clk_o,
  input logic [7:0] cfg_data_o,
  input logic       mem_rd_o,
  input logic       ok_o,
  input logic       err_o,
  input logic       tmo_o
);
  logic [15:0] hi_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hi_len <= '0;
    else if (!cfg_clk_o)      hi_len <= '0;
    else if (hi_len != '1)    hi_len <= hi_len + 16'd1;
  end

  p_req_in_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_req_no |-> busy_o);

  p_data_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_clk_o |-> $stable(cfg_data_o));

  p_single_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  p_half_period_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cfg_clk_o) && !err_o) |-> (hi_len == 16'(HALF_DIV)));

  p_no_fetch_after_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !mem_rd_o);

  p_ok_on_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> ($past(init_done_i) && !$past(init_done_i, 2)));

  p_status_stops_clk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_ni |-> ##2 !cfg_clk_o);

  p_one_result_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_o, err_o, tmo_o}));

  p_no_result_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(ok_o || err_o || tmo_o));
endmodule

bind cfg_loader cfg_loader_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_req_no (cfg_req_no),
  .busy_o     (busy_o),
  .status_ni  (status_ni),
  .done_i     (done_i),
  .init_done_i(init_done_i),
  .cfg_clk_o  (cfg_clk_o),
  .cfg_data_o (cfg_data_o),
  .mem_rd_o   (mem_rd_o),
  .ok_o       (ok_o),
  .err_o      (err_o),
  .tmo_o      (tmo_o)
);

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;
  localparam int ADDR_W   = 12;
  localparam int CNT_W    = ADDR_W + 1;
  localparam int REQ_CYC  = 4;
  localparam int HALF_DIV = 4;
  localparam int INIT_TMO = 300;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [CNT_W-1:0]  byte_count_i = '0;
  logic [ADDR_W-1:0] mem_addr_o;
  logic              mem_rd_o;
  logic [7:0]        mem_data = '0;
  logic              cfg_req_no;
  logic              status_ni = 1'b1;
  logic              done_i = 1'b0;
  logic              init_done_i = 1'b0;
  logic              cfg_clk_o;
  logic [7:0]        cfg_data_o;
  logic              busy_o, ok_o, err_o, tmo_o;

  cfg_loader #(.ADDR_W(ADDR_W), .REQ_CYC(REQ_CYC), .HALF_DIV(HALF_DIV), .INIT_TMO(INIT_TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_data_i(mem_data),
    .cfg_req_no(cfg_req_no), .status_ni(status_ni), .done_i(done_i),
    .init_done_i(init_done_i), .cfg_clk_o(cfg_clk_o), .cfg_data_o(cfg_data_o),
    .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o), .tmo_o(tmo_o)
  );

  function automatic logic [7:0] mem_val(input logic [ADDR_W-1:0] a);
    return 8'(a * 37 + 5) ^ 8'(a >> 3);
  endfunction

  always_ff @(posedge clk) if (mem_rd_o) mem_data <= mem_val(mem_addr_o);

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // target model settings, written by the driver only
  int done_at = 0, drop_at = 0, init_mode = 0, init_dly = 1, rel_dly = 0;

  // target model state and cumulative monitors
  logic [7:0] sb_q[$];
  int cap_n = 0, fall_n = 0, rise_after = 0, rd_n = 0, req_w = 0, req_pulses = 0;
  int pre_bad = 0, hp_bad = 0, hi_run = 0, rel_cnt = 0, init_cnt = -1;
  bit released = 1'b1, prev_clk = 1'b0, prev_req = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cfg_req_no) begin
        if (prev_req) begin req_pulses++; req_w = 1; end
        else req_w++;
        status_ni = 1'b0; released = 1'b0; rel_cnt = rel_dly;
        cap_n = 0; fall_n = 0; rise_after = 0; rd_n = 0;
        done_i = 1'b0; init_done_i = (init_mode == 2); init_cnt = -1;
      end else begin
        if (!status_ni && cap_n == 0 && (mem_rd_o || cfg_clk_o)) pre_bad++;
        if (mem_rd_o) rd_n++;
        if (!released) begin
          if (rel_cnt == 0) begin status_ni = 1'b1; released = 1'b1; end
          else rel_cnt--;
        end
        // scoreboard monitor: each captured byte is popped and compared
        if (cfg_clk_o && !prev_clk) begin
          if (done_i) rise_after++;
          else begin
            cap_n++;
            if (sb_q.size() == 0) chk(1'b0, "R4 unexpected byte", cap_n, 0);
            else begin
              logic [7:0] e;
              e = sb_q.pop_front();
              chk(cfg_data_o == e, "R4 byte value/order", int'(cfg_data_o), int'(e));
            end
            if (cap_n == done_at) done_i = 1'b1;
            if (cap_n == drop_at) status_ni = 1'b0;
          end
        end
        if (!cfg_clk_o && prev_clk && done_i) begin
          fall_n++;
          if (fall_n == 2 && init_mode == 1) init_cnt = init_dly;
        end
        if (init_cnt > 0) init_cnt--;
        else if (init_cnt == 0) begin init_done_i = 1'b1; init_cnt = -1; end
        if (cfg_clk_o) hi_run++;
        else begin
          if (prev_clk && !err_o && hi_run != HALF_DIV) hp_bad++;
          hi_run = 0;
        end
      end
      prev_clk = cfg_clk_o;
      prev_req = cfg_req_no;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // driver: sets the target, queues the expected bytes, runs one image
  task automatic run_case(input int n, input int d_at, input int dr_at, input int imode,
                          input int idly, input int rdly, input bit poke);
    int exp_n;
    int pulses0, pre0, hp0;
    done_at = d_at; drop_at = dr_at; init_mode = imode; init_dly = idly; rel_dly = rdly;
    exp_n = (dr_at != 0) ? dr_at : ((d_at != 0) ? d_at : n);
    sb_q.delete();
    for (int a = 0; a < exp_n; a++) sb_q.push_back(mem_val(ADDR_W'(a)));
    pulses0 = req_pulses; pre0 = pre_bad; hp0 = hp_bad;
    @(negedge clk); start_i = 1'b1; byte_count_i = CNT_W'(n);
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
    chk(!(ok_o || err_o || tmo_o), "R12 result cleared by start", int'({ok_o, err_o, tmo_o}), 0);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy_o) break;
      start_i = (poke && i == 30);
    end
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_w == REQ_CYC, "R2 request width", req_w, REQ_CYC);
    chk(req_pulses - pulses0 == 1, "R12 one request pulse", req_pulses - pulses0, 1);
    chk(pre_bad == pre0, "R3 quiet before release", pre_bad - pre0, 0);
    chk(hp_bad == hp0, "R5 high phase length", hp_bad - hp0, 0);
    chk(sb_q.size() == 0, "R4 all expected bytes seen", sb_q.size(), 0);
    chk(cap_n == exp_n, "R4 bytes captured", cap_n, exp_n);
    chk(cfg_clk_o == 1'b0, "R7 clock parked low", int'(cfg_clk_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cfg_req_no == 1'b1 && cfg_clk_o == 1'b0 && mem_rd_o == 1'b0, "R1 reset outputs",
        int'({cfg_req_no, cfg_clk_o, mem_rd_o}), 4);
    chk(!(busy_o || ok_o || err_o || tmo_o), "R1 reset flags", int'({busy_o, ok_o, err_o, tmo_o}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cfg_req_no == 1'b1 && !busy_o && !cfg_clk_o, "R1 idle after reset",
        int'({cfg_req_no, busy_o, cfg_clk_o}), 4);

    // done one byte early, init edge arrives, second start mid-run
    run_case(10, 9, 0, 1, 5, 6, 1'b1);
    chk(ok_o && !err_o && !tmo_o, "R8 success on init edge", int'({ok_o, err_o, tmo_o}), 4);
    chk(rd_n == 9, "R6 reads stop at done", rd_n, 9);
    chk(fall_n == 2, "R7 trailing falls", fall_n, 2);
    chk(rise_after == 1, "R7 trailing rises", rise_after, 1);

    // done on the very last counted byte
    run_case(3, 3, 0, 1, 2, 2, 1'b0);
    chk(ok_o && !err_o, "R6 done on last byte is success", int'({ok_o, err_o}), 2);
    chk(rd_n == 3, "R6 reads equal captures", rd_n, 3);

    // status drops after the fourth byte
    run_case(10, 9, 4, 1, 2, 3, 1'b0);
    chk(err_o && !ok_o, "R9 status drop sets error", int'({ok_o, err_o}), 1);

    // done never rises: error after exactly the counted bytes
    run_case(6, 0, 0, 1, 2, 1, 1'b0);
    chk(err_o && !ok_o && !tmo_o, "R10 count exhausted", int'({ok_o, err_o, tmo_o}), 2);
    repeat (20) @(negedge clk);
    chk(err_o == 1'b1, "R12 error is sticky", int'(err_o), 1);

    // no init-done edge at all
    run_case(5, 4, 0, 0, 1, 2, 1'b0);
    chk(tmo_o && !ok_o && !err_o, "R11 timeout without init edge", int'({ok_o, err_o, tmo_o}), 1);
    chk(fall_n == 2, "R7 trailing falls before timeout", fall_n, 2);

    // init-done already high: a level is not an edge
    run_case(5, 4, 0, 2, 1, 2, 1'b0);
    chk(tmo_o && !ok_o, "R8 high level gives no success", int'({ok_o, tmo_o}), 1);

    // longer image, immediate release
    run_case(20, 19, 0, 1, 9, 0, 1'b0);
    chk(ok_o && !err_o && !tmo_o, "R8 success long image", int'({ok_o, err_o, tmo_o}), 4);
    chk(rd_n == 19, "R6 reads long image", rd_n, 19);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule